// File: doc/BRIEF.md
# Bus-Mastering Endpoint Test Controller

The block is a test function that sits behind a bus endpoint. A host programs it through a small word-indexed register port. The host loads a source address, a destination address, a transfer length in words, an interrupt kind and an interrupt number, then writes a command word. The controller carries out that command on its own. It can raise an interrupt directly. It can also act as a bus master: it fetches a host buffer, fills a host buffer with a generated pattern, or moves one host buffer to another. The result is posted as per-operation success, fail and bad-address flags in a status register.

When a buffer operation ends, the controller raises a completion interrupt of the programmed kind, provided the programmed number is legal for that kind. The memory side is a request/ready channel with a separate read-response strobe, and only one request is outstanding at a time. A scratch register that holds any written value lets the host confirm that the register window is reachable.

Register word indices: 0 scratch, 1 command, 2 status, 3 source address, 4 destination address, 5 length in words, 6 checksum (read-only), 7 interrupt kind, 8 interrupt number. All other indices read zero.

Top module: `ep_test_ctrl`

## Requirements
- R1: The scratch register (index 0) returns exactly the last 32-bit value written to it.
- R2: After reset every register reads zero, no memory request is valid and no interrupt line is active.
- R3: Command bits are bit 0 legacy raise, bit 1 MSI raise, bit 2 MSI-X raise, bit 3 buffer read, bit 4 buffer write, bit 5 buffer copy. When several bits are set, only the lowest set bit is executed. A command word with no bit set starts nothing.
- R4: A read fetches `length` words starting at the source address, with the address stepping by 4 per word. It stores the XOR of all fetched words in the checksum register and sets status bit 0 (bit 1 is the read fail flag).
- R5: A write stores word value i at destination + 4*i for i = 0..length-1. It stores the XOR of those values as the checksum and sets status bit 2 (bit 3 is the write fail flag).
- R6: A copy reads each source word and writes it to the same offset at the destination before fetching the next word. It stores the XOR of the moved words and sets status bit 4 (bit 5 is the copy fail flag).
- R7: An address that is zero or has either of its two low bits set is invalid. A bad source sets status bit 7, a bad destination sets status bit 8, and the operation's fail bit is set as well. No memory request is issued and the checksum register is left unchanged.
- R8: A raise command pulses the interrupt line that the command bit selects. Legal numbers are 0 for legacy, 1..32 for MSI and 1..2048 for MSI-X. A legal number also sets status bit 6. An illegal number gives no pulse and leaves bit 6 clear.
- R9: At the end of a read, write or copy, whether it succeeded or failed, the kind register (0 legacy, 1 MSI, 2 MSI-X, 3 none) selects the completion interrupt, checked for a legal number as in R8. Kind 3 never interrupts.
- R10: A command write accepted while idle clears the status register. The command register reads back the written word while the operation runs and reads zero once it ends. A command write that arrives while busy is ignored.
- R11: A memory request, once valid, holds its address, direction and data unchanged until it is accepted.
- R12: Each interrupt is a single-cycle pulse on one line only, with the interrupt number presented on `irq_num` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 32 | Read response data |
| irq_legacy | output | 1 | Legacy interrupt pulse |
| irq_msi | output | 1 | MSI interrupt pulse |
| irq_msix | output | 1 | MSI-X interrupt pulse |
| irq_num | output | 12 | Interrupt number sent with a pulse |

## Verification
The assertions watch the bus and interrupt boundary on every cycle. They check that a request never carries a zero or misaligned address, that a stalled request stays stable, and that no request appears while idle. They also check that interrupt lines are one-hot single-cycle pulses with numbers in the legal range for their kind, that no two status flags of the same operation are set together, and that the scratch register reads back what was written. Only the bench scenarios can show the actual data: the checksum values, the word order and pattern on writes and copies, the priority among command bits, the effect of ignored commands, and which legal or illegal number and kind combinations produce a completion interrupt.

// File: rtl/ep_test_pkg.sv
package ep_test_pkg;

    parameter int DW        = 32;
    parameter int AW        = 32;
    parameter int SIZE_W    = 16;
    parameter int IRQ_NUM_W = 12;
    parameter int REG_IDX_W = 4;
    parameter int CMD_W     = 6;
    parameter int STAT_W    = 9;
    parameter int MSI_MAX   = 32;
    parameter int MSIX_MAX  = 2048;

    localparam int BYTES      = DW / 8;
    localparam int ALIGN_BITS = $clog2(BYTES);

    localparam logic [REG_IDX_W-1:0] IDX_SCRATCH = 4'd0;
    localparam logic [REG_IDX_W-1:0] IDX_CMD     = 4'd1;
    localparam logic [REG_IDX_W-1:0] IDX_STATUS  = 4'd2;
    localparam logic [REG_IDX_W-1:0] IDX_SRC     = 4'd3;
    localparam logic [REG_IDX_W-1:0] IDX_DST     = 4'd4;
    localparam logic [REG_IDX_W-1:0] IDX_LEN     = 4'd5;
    localparam logic [REG_IDX_W-1:0] IDX_CSUM    = 4'd6;
    localparam logic [REG_IDX_W-1:0] IDX_KIND    = 4'd7;
    localparam logic [REG_IDX_W-1:0] IDX_NUM     = 4'd8;

    localparam int ST_RD_OK   = 0;
    localparam int ST_WR_OK   = 2;
    localparam int ST_CP_OK   = 4;
    localparam int ST_IRQ     = 6;
    localparam int ST_SRC_BAD = 7;
    localparam int ST_DST_BAD = 8;

    typedef enum logic [1:0] {
        IRQ_LEGACY = 2'd0,
        IRQ_MSI    = 2'd1,
        IRQ_MSIX   = 2'd2,
        IRQ_NONE   = 2'd3
    } irq_kind_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RAISE_LEG,
        OP_RAISE_MSI,
        OP_RAISE_MSIX,
        OP_READ,
        OP_WRITE,
        OP_COPY
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_NEXT,
        S_RD,
        S_RSP,
        S_WR,
        S_IRQ
    } seq_state_e;

    typedef struct packed {
        op_e                  op;
        logic [AW-1:0]        src;
        logic [AW-1:0]        dst;
        logic [SIZE_W-1:0]    len;
        irq_kind_e            kind;
        logic [IRQ_NUM_W-1:0] num;
    } job_t;

    // lowest set command bit wins
    function automatic op_e decode_cmd(logic [CMD_W-1:0] c);
        if (c[0])      return OP_RAISE_LEG;
        else if (c[1]) return OP_RAISE_MSI;
        else if (c[2]) return OP_RAISE_MSIX;
        else if (c[3]) return OP_READ;
        else if (c[4]) return OP_WRITE;
        else if (c[5]) return OP_COPY;
        else           return OP_NONE;
    endfunction

    function automatic logic irq_num_ok(irq_kind_e k, logic [IRQ_NUM_W-1:0] n);
        case (k)
            IRQ_LEGACY: return n == '0;
            IRQ_MSI:    return (n >= 1) && (n <= IRQ_NUM_W'(MSI_MAX));
            IRQ_MSIX:   return (n >= 1) && (n <= IRQ_NUM_W'(MSIX_MAX));
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic addr_bad(logic [AW-1:0] a);
        return (a == '0) || (a[ALIGN_BITS-1:0] != '0);
    endfunction

    function automatic int ok_bit(op_e op);
        case (op)
            OP_READ:  return ST_RD_OK;
            OP_WRITE: return ST_WR_OK;
            default:  return ST_CP_OK;
        endcase
    endfunction

    function automatic logic is_raise(op_e op);
        return (op == OP_RAISE_LEG) || (op == OP_RAISE_MSI) || (op == OP_RAISE_MSIX);
    endfunction

    function automatic irq_kind_e raise_kind(op_e op);
        case (op)
            OP_RAISE_LEG: return IRQ_LEGACY;
            OP_RAISE_MSI: return IRQ_MSI;
            default:      return IRQ_MSIX;
        endcase
    endfunction

endpackage

// File: rtl/ep_test_regs.sv
module ep_test_regs
    import ep_test_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    input  logic                 busy,
    input  logic                 seq_done,
    input  logic                 seq_ok,
    input  logic [DW-1:0]        seq_csum,
    input  logic [STAT_W-1:0]    status,
    output logic                 start,
    output job_t                 job
);

    logic [DW-1:0]        scratch_q;
    logic [CMD_W-1:0]     cmd_q;
    logic [AW-1:0]        src_q;
    logic [AW-1:0]        dst_q;
    logic [SIZE_W-1:0]    len_q;
    logic [DW-1:0]        csum_q;
    logic [1:0]           kind_q;
    logic [IRQ_NUM_W-1:0] num_q;

    assign start = wr && (idx == IDX_CMD) && !busy && (wdata[CMD_W-1:0] != '0);

    always_comb begin
        job.op   = decode_cmd(wdata[CMD_W-1:0]);
        job.src  = src_q;
        job.dst  = dst_q;
        job.len  = len_q;
        job.kind = irq_kind_e'(kind_q);
        job.num  = num_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            cmd_q     <= '0;
            src_q     <= '0;
            dst_q     <= '0;
            len_q     <= '0;
            csum_q    <= '0;
            kind_q    <= '0;
            num_q     <= '0;
        end else begin
            if (wr) begin
                case (idx)
                    IDX_SCRATCH: scratch_q <= wdata;
                    IDX_SRC:     src_q     <= wdata[AW-1:0];
                    IDX_DST:     dst_q     <= wdata[AW-1:0];
                    IDX_LEN:     len_q     <= wdata[SIZE_W-1:0];
                    IDX_KIND:    kind_q    <= wdata[1:0];
                    IDX_NUM:     num_q     <= wdata[IRQ_NUM_W-1:0];
                    default: ;
                endcase
            end
            if (start)
                cmd_q <= wdata[CMD_W-1:0];
            else if (seq_done)
                cmd_q <= '0;
            if (seq_done && seq_ok)
                csum_q <= seq_csum;
        end
    end

    always_comb begin
        case (idx)
            IDX_SCRATCH: rdata = scratch_q;
            IDX_CMD:     rdata = DW'(cmd_q);
            IDX_STATUS:  rdata = DW'(status);
            IDX_SRC:     rdata = DW'(src_q);
            IDX_DST:     rdata = DW'(dst_q);
            IDX_LEN:     rdata = DW'(len_q);
            IDX_CSUM:    rdata = csum_q;
            IDX_KIND:    rdata = DW'(kind_q);
            IDX_NUM:     rdata = DW'(num_q);
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/ep_test_seq.sv
module ep_test_seq
    import ep_test_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  job_t                 job,
    output logic                 busy,
    output logic                 done,
    output logic                 ok,
    output logic [DW-1:0]        csum,
    output logic [STAT_W-1:0]    status,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic                 req_write,
    output logic [AW-1:0]        req_addr,
    output logic [DW-1:0]        req_wdata,
    input  logic                 rsp_valid,
    input  logic [DW-1:0]        rsp_data,
    output logic                 irq_fire,
    output irq_kind_e            irq_kind,
    output logic [IRQ_NUM_W-1:0] irq_num
);

    seq_state_e        state;
    job_t              job_q;
    logic [SIZE_W-1:0] cnt;
    logic [DW-1:0]     hold;
    logic              need_src;
    logic              need_dst;
    logic              src_bad;
    logic              dst_bad;
    logic [AW-1:0]     offset;

    assign need_src = (job_q.op == OP_READ)  || (job_q.op == OP_COPY);
    assign need_dst = (job_q.op == OP_WRITE) || (job_q.op == OP_COPY);
    assign src_bad  = need_src && addr_bad(job_q.src);
    assign dst_bad  = need_dst && addr_bad(job_q.dst);
    assign offset   = AW'(cnt) << ALIGN_BITS;

    assign busy      = (state != S_IDLE);
    assign done      = (state == S_IRQ);
    assign req_valid = (state == S_RD) || (state == S_WR);
    assign req_write = (state == S_WR);
    assign req_addr  = (state == S_WR) ? (job_q.dst + offset) : (job_q.src + offset);
    assign req_wdata = (job_q.op == OP_COPY) ? hold : DW'(cnt);

    assign irq_kind = is_raise(job_q.op) ? raise_kind(job_q.op) : job_q.kind;
    assign irq_num  = job_q.num;
    assign irq_fire = (state == S_IRQ) && irq_num_ok(irq_kind, irq_num);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            job_q  <= '0;
            cnt    <= '0;
            hold   <= '0;
            csum   <= '0;
            ok     <= 1'b0;
            status <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        job_q  <= job;
                        cnt    <= '0;
                        csum   <= '0;
                        ok     <= 1'b0;
                        status <= '0;
                        state  <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (is_raise(job_q.op)) begin
                        state <= S_IRQ;
                    end else if (src_bad || dst_bad) begin
                        status[ST_SRC_BAD]             <= src_bad;
                        status[ST_DST_BAD]             <= dst_bad;
                        status[ok_bit(job_q.op) + 1]   <= 1'b1;
                        state                          <= S_IRQ;
                    end else begin
                        state <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (cnt == job_q.len) begin
                        status[ok_bit(job_q.op)] <= 1'b1;
                        ok                       <= 1'b1;
                        state                    <= S_IRQ;
                    end else if (job_q.op == OP_WRITE) begin
                        state <= S_WR;
                    end else begin
                        state <= S_RD;
                    end
                end
                S_RD: begin
                    if (req_ready)
                        state <= S_RSP;
                end
                S_RSP: begin
                    if (rsp_valid) begin
                        csum <= csum ^ rsp_data;
                        hold <= rsp_data;
                        if (job_q.op == OP_COPY) begin
                            state <= S_WR;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            state <= S_NEXT;
                        end
                    end
                end
                S_WR: begin
                    if (req_ready) begin
                        if (job_q.op == OP_WRITE)
                            csum <= csum ^ req_wdata;
                        cnt   <= cnt + 1'b1;
                        state <= S_NEXT;
                    end
                end
                S_IRQ: begin
                    if (irq_fire)
                        status[ST_IRQ] <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ep_test_irq.sv
module ep_test_irq
    import ep_test_pkg::*;
#(
    parameter int N_LINES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  irq_kind_e            kind,
    input  logic [IRQ_NUM_W-1:0] num_in,
    output logic [N_LINES-1:0]   lines,
    output logic [IRQ_NUM_W-1:0] num_out
);

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                lines[k] <= 1'b0;
            else
                lines[k] <= fire && (kind == irq_kind_e'(k));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            num_out <= '0;
        else if (fire)
            num_out <= num_in;
    end

endmodule

// File: rtl/ep_test_ctrl.sv
module ep_test_ctrl
    import ep_test_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_IDX_W-1:0] reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_write,
    output logic [AW-1:0]        mem_req_addr,
    output logic [DW-1:0]        mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [DW-1:0]        mem_rsp_data,
    output logic                 irq_legacy,
    output logic                 irq_msi,
    output logic                 irq_msix,
    output logic [IRQ_NUM_W-1:0] irq_num
);

    logic                 start;
    job_t                 job;
    logic                 busy;
    logic                 done;
    logic                 ok;
    logic [DW-1:0]        csum;
    logic [STAT_W-1:0]    status;
    logic                 fire;
    irq_kind_e            fire_kind;
    logic [IRQ_NUM_W-1:0] fire_num;
    logic [2:0]           lines;

    ep_test_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .idx      (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .busy     (busy),
        .seq_done (done),
        .seq_ok   (ok),
        .seq_csum (csum),
        .status   (status),
        .start    (start),
        .job      (job)
    );

    ep_test_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .job       (job),
        .busy      (busy),
        .done      (done),
        .ok        (ok),
        .csum      (csum),
        .status    (status),
        .req_valid (mem_req_valid),
        .req_ready (mem_req_ready),
        .req_write (mem_req_write),
        .req_addr  (mem_req_addr),
        .req_wdata (mem_req_wdata),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .irq_fire  (fire),
        .irq_kind  (fire_kind),
        .irq_num   (fire_num)
    );

    ep_test_irq #(.N_LINES(3)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .kind    (fire_kind),
        .num_in  (fire_num),
        .lines   (lines),
        .num_out (irq_num)
    );

    assign irq_legacy = lines[0];
    assign irq_msi    = lines[1];
    assign irq_msix   = lines[2];

endmodule

// File: rtl/ep_test_ctrl_chk.sv
module ep_test_ctrl_chk
    import ep_test_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr,
    input logic [REG_IDX_W-1:0] reg_addr,
    input logic [DW-1:0]        reg_wdata,
    input logic [DW-1:0]        reg_rdata,
    input logic                 mem_req_valid,
    input logic                 mem_req_ready,
    input logic                 mem_req_write,
    input logic [AW-1:0]        mem_req_addr,
    input logic [DW-1:0]        mem_req_wdata,
    input logic                 irq_legacy,
    input logic                 irq_msi,
    input logic                 irq_msix,
    input logic [IRQ_NUM_W-1:0] irq_num,
    input logic                 busy,
    input logic [STAT_W-1:0]    status
);

    assert_scratch_hold_R1: assert property (@(posedge clk) disable iff (rst)
        reg_wr && reg_addr == IDX_SCRATCH |=>
            (reg_addr != IDX_SCRATCH) || (reg_rdata == $past(reg_wdata)));

    assert_idle_no_req_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);

    assert_req_addr_legal_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr != '0) && (mem_req_addr[ALIGN_BITS-1:0] == '0));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
            && $stable(mem_req_wdata));

    assert_irq_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({irq_legacy, irq_msi, irq_msix}));

    assert_irq_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_legacy || irq_msi || irq_msix) |=> !(irq_legacy || irq_msi || irq_msix));

    assert_legacy_num_R8: assert property (@(posedge clk) disable iff (rst)
        irq_legacy |-> irq_num == '0);

    assert_msi_num_R8: assert property (@(posedge clk) disable iff (rst)
        irq_msi |-> (irq_num >= 1) && (irq_num <= IRQ_NUM_W'(MSI_MAX)));

    assert_msix_num_R8: assert property (@(posedge clk) disable iff (rst)
        irq_msix |-> (irq_num >= 1) && (irq_num <= IRQ_NUM_W'(MSIX_MAX)));

    assert_status_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(status[0] && status[1]));

    assert_status_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(status[2] && status[3]));

    assert_status_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(status[5:0]) <= 1);

endmodule

bind ep_test_ctrl ep_test_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .irq_legacy    (irq_legacy),
    .irq_msi       (irq_msi),
    .irq_msix      (irq_msix),
    .irq_num       (irq_num),
    .busy          (busy),
    .status        (status)
);

// File: tb/ep_test_ctrl_tb.sv
module ep_test_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        irq_legacy;
    logic        irq_msi;
    logic        irq_msix;
    logic [11:0] irq_num;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ep_test_ctrl dut_i (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .irq_legacy(irq_legacy), .irq_msi(irq_msi), .irq_msix(irq_msix), .irq_num(irq_num)
    );

    // ---------------- memory and interrupt models ----------------
    function automatic logic [31:0] memf(logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'h5A5A_00FF;
    endfunction

    logic [7:0]  lfsr;
    int          rd_cnt = 0;
    int          wcnt = 0;
    logic [31:0] wlog_addr [0:63];
    logic [31:0] wlog_data [0:63];
    int          irq_cnt = 0;
    int          last_kind = -1;
    logic [11:0] last_num = '0;

    always @(posedge clk) begin
        if (rst) begin
            lfsr          <= 8'hA1;
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            mem_req_ready <= lfsr[0] | lfsr[2];
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    wlog_addr[wcnt % 64] <= mem_req_addr;
                    wlog_data[wcnt % 64] <= mem_req_wdata;
                    wcnt <= wcnt + 1;
                end else begin
                    rd_cnt        <= rd_cnt + 1;
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= memf(mem_req_addr);
                end
            end
        end
        if (!rst && (irq_legacy || irq_msi || irq_msix)) begin
            irq_cnt   <= irq_cnt + 1;
            last_kind <= irq_legacy ? 0 : (irq_msi ? 1 : 2);
            last_num  <= irq_num;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input logic cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] c;
        for (int i = 0; i < 4000; i++) begin
            reg_read(4'd1, c);
            if (c == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic logic num_legal(int k, int n);
        if (k == 0) return n == 0;
        if (k == 1) return n >= 1 && n <= 32;
        if (k == 2) return n >= 1 && n <= 2048;
        return 1'b0;
    endfunction

    task automatic setup(input logic [31:0] s, input logic [31:0] d, input int len,
                         input int kind, input int num);
        reg_write(4'd3, s);
        reg_write(4'd4, d);
        reg_write(4'd5, len);
        reg_write(4'd7, kind);
        reg_write(4'd8, num);
    endtask

    // runs one command, checks status, interrupt and request counts
    task automatic run_op(input string req, input logic [31:0] cmd, input logic [31:0] exp_stat,
                          input int exp_irq_kind, input int exp_num, input int exp_rd,
                          input int exp_wr);
        int irq0, rd0, wr0;
        logic [31:0] st;
        irq0 = irq_cnt; rd0 = rd_cnt; wr0 = wcnt;
        reg_write(4'd1, cmd);
        wait_done();
        reg_read(4'd2, st);
        check(st == exp_stat, req, "status", st, exp_stat);
        check(rd_cnt - rd0 == exp_rd, req, "read requests", rd_cnt - rd0, exp_rd);
        check(wcnt - wr0 == exp_wr, req, "write requests", wcnt - wr0, exp_wr);
        if (exp_irq_kind < 0) begin
            check(irq_cnt == irq0, req, "no interrupt", irq_cnt - irq0, 0);
        end else begin
            check(irq_cnt == irq0 + 1, req, "interrupt count", irq_cnt - irq0, 1);
            check(last_kind == exp_irq_kind, req, "interrupt kind", last_kind, exp_irq_kind);
            check(last_num == exp_num[11:0], req, "interrupt number", last_num, exp_num);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [31:0] v;
        logic [31:0] csum;
        logic [31:0] prev_csum;
        int nums [6];
        nums = '{0, 1, 32, 33, 2048, 2049};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2: reset state
        for (int r = 0; r < 16; r++) begin
            reg_read(r[3:0], v);
            check(v == 0, "R2", "register after reset", v, 0);
        end
        check(!mem_req_valid && !irq_legacy && !irq_msi && !irq_msix, "R2", "outputs idle",
              {mem_req_valid, irq_legacy, irq_msi, irq_msix}, 0);

        // R1: scratch readback
        foreach (nums[i]) begin
            logic [31:0] p;
            p = 32'hA5C3_0F00 ^ (32'h0101_0101 * nums[i]) ^ (i * 32'h1357_9BDF);
            reg_write(4'd0, p);
            reg_read(4'd0, v);
            check(v == p, "R1", "scratch readback", v, p);
        end
        reg_write(4'd0, 32'hFFFF_FFFF);
        reg_read(4'd0, v);
        check(v == 32'hFFFF_FFFF, "R1", "scratch all ones", v, 32'hFFFF_FFFF);

        // R4: read sweep, MSI completion number 5 (R9)
        for (int n = 0; n <= 5; n++) begin
            logic [31:0] s;
            s = 32'h1000 + n * 32'h100;
            csum = 0;
            for (int i = 0; i < n; i++) csum ^= memf(s + 4 * i);
            setup(s, 32'h8000, n, 1, 5);
            run_op("R4", 32'h08, 32'h041, 1, 5, n, 0);
            reg_read(4'd6, v);
            check(v == csum, "R4", "read checksum", v, csum);
        end

        // R5: write sweep with legacy completion (R9)
        for (int n = 0; n <= 5; n++) begin
            int base;
            logic [31:0] d;
            d = 32'h2000 + n * 32'h40;
            base = wcnt;
            csum = 0;
            for (int i = 0; i < n; i++) csum ^= i;
            setup(32'h4, d, n, 0, 0);
            run_op("R5", 32'h10, 32'h044, 0, 0, 0, n);
            for (int i = 0; i < n; i++) begin
                check(wlog_addr[(base + i) % 64] == d + 4 * i, "R5", "write address",
                      wlog_addr[(base + i) % 64], d + 4 * i);
                check(wlog_data[(base + i) % 64] == i, "R5", "write pattern",
                      wlog_data[(base + i) % 64], i);
            end
            reg_read(4'd6, v);
            check(v == csum, "R5", "write checksum", v, csum);
        end

        // R6: copy sweep with MSI-X completion (R9)
        for (int n = 0; n <= 4; n++) begin
            int base;
            logic [31:0] s, d;
            s = 32'h3000 + n * 32'h20;
            d = 32'h6000 + n * 32'h80;
            base = wcnt;
            csum = 0;
            for (int i = 0; i < n; i++) csum ^= memf(s + 4 * i);
            setup(s, d, n, 2, 2048);
            run_op("R6", 32'h20, 32'h050, 2, 2048, n, n);
            for (int i = 0; i < n; i++) begin
                check(wlog_addr[(base + i) % 64] == d + 4 * i, "R6", "copy address",
                      wlog_addr[(base + i) % 64], d + 4 * i);
                check(wlog_data[(base + i) % 64] == memf(s + 4 * i), "R6", "copy data",
                      wlog_data[(base + i) % 64], memf(s + 4 * i));
            end
            reg_read(4'd6, v);
            check(v == csum, "R6", "copy checksum", v, csum);
        end

        // R7: invalid addresses, checksum must stay unchanged
        reg_read(4'd6, prev_csum);
        setup(32'h0, 32'h8000, 3, 0, 0);
        run_op("R7", 32'h08, 32'h0C2, 0, 0, 0, 0);
        setup(32'h1002, 32'h8000, 3, 0, 0);
        run_op("R7", 32'h08, 32'h0C2, 0, 0, 0, 0);
        setup(32'h1000, 32'h8001, 3, 0, 0);
        run_op("R7", 32'h10, 32'h148, 0, 0, 0, 0);
        setup(32'h1003, 32'h8000, 3, 0, 0);
        run_op("R7", 32'h20, 32'h0E0, 0, 0, 0, 0);
        setup(32'h1000, 32'h0, 3, 0, 0);
        run_op("R7", 32'h20, 32'h160, 0, 0, 0, 0);
        setup(32'h0, 32'h2, 3, 3, 0);
        run_op("R7", 32'h20, 32'h1A0, -1, 0, 0, 0);
        reg_read(4'd6, v);
        check(v == prev_csum, "R7", "checksum untouched", v, prev_csum);

        // R8: explicit raises over kinds and boundary numbers
        for (int k = 0; k < 3; k++) begin
            foreach (nums[i]) begin
                logic ok_n;
                ok_n = num_legal(k, nums[i]);
                setup(32'h1000, 32'h2000, 2, 3, nums[i]);
                run_op("R8", 32'h1 << k, ok_n ? 32'h040 : 32'h0, ok_n ? k : -1,
                       nums[i], 0, 0);
            end
        end

        // R9: completion kind and number combinations on a one-word read
        for (int k = 0; k < 4; k++) begin
            foreach (nums[i]) begin
                logic ok_n;
                ok_n = num_legal(k, nums[i]);
                setup(32'h1000, 32'h2000, 1, k, nums[i]);
                run_op("R9", 32'h08, ok_n ? 32'h041 : 32'h001, ok_n ? k : -1,
                       nums[i], 1, 0);
            end
        end

        // R3: lowest set bit wins, zero command starts nothing
        setup(32'h1000, 32'h2000, 2, 1, 7);
        run_op("R3", 32'h18, 32'h041, 1, 7, 2, 0);
        setup(32'h1000, 32'h2000, 2, 1, 0);
        run_op("R3", 32'h3F, 32'h040, 0, 0, 0, 0);
        setup(32'h1000, 32'h2000, 2, 1, 3);
        run_op("R3", 32'h34, 32'h040, 2, 3, 0, 0);
        setup(32'h1000, 32'h2000, 2, 1, 3);
        run_op("R3", 32'h30, 32'h044, 1, 3, 0, 2);
        reg_write(4'd1, 32'h0);
        reg_read(4'd1, v);
        check(v == 0, "R3", "empty command not started", v, 0);
        reg_read(4'd2, v);
        check(v == 32'h044, "R3", "empty command keeps status", v, 32'h044);

        // R10: status cleared on start, command readback, busy writes ignored
        begin
            int base;
            setup(32'h1000, 32'h2400, 6, 1, 9);
            base = wcnt;
            reg_write(4'd1, 32'h10);
            reg_read(4'd2, v);
            check(v == 0, "R10", "status cleared at start", v, 0);
            reg_read(4'd1, v);
            check(v == 32'h10, "R10", "command while busy", v, 32'h10);
            reg_write(4'd1, 32'h20);
            reg_read(4'd1, v);
            check(v == 32'h10, "R10", "busy command ignored", v, 32'h10);
            wait_done();
            reg_read(4'd1, v);
            check(v == 0, "R10", "command cleared after done", v, 0);
            reg_read(4'd2, v);
            check(v == 32'h044, "R10", "only first command ran", v, 32'h044);
            check(wcnt - base == 6, "R10", "write count", wcnt - base, 6);
            check(wlog_data[(base + 5) % 64] == 5, "R10", "pattern not copy data",
                  wlog_data[(base + 5) % 64], 5);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule